// File: doc/BRIEF.md
# Ternary Match Table with Longest-Prefix Selection

This block is a small ternary lookup table. It holds a fixed number of slots. Each slot stores a value word, a care mask of the same width and a valid flag. A bit whose care bit is 0 is a wildcard: it matches either key value. A bit whose care bit is 1 must equal the key bit. A search key exactly one slot wide is compared against every slot at once, so a search costs the same single cycle whatever the slot count.

Several slots can hit the same key. In that case the block selects one winner. The winner is the hitting slot with the largest number of care bits, which is the longest prefix when the masks are prefix masks. Among equally long hits, the lowest slot index wins. The hit flag and the winning index are registered and appear one clock after the search strobe. A write port loads one slot per cycle.

Top module: `tcam_lpm`

## Requirements
- R1: After reset all slots are invalid, and res_valid, res_hit and res_idx are all 0.
- R2: A search strobed on srch_en at a rising edge produces res_valid=1 with its result after exactly that edge; res_valid is 0 after an edge with no strobe; back-to-back strobes give one result per cycle.
- R3: A slot hits a key when it is valid and the key equals the stored value on every bit position where the slot's care bit is 1; positions with care bit 0 never prevent a hit.
- R4: A slot whose valid flag is 0 never hits; a write with wr_valid=0 removes a slot from all later searches.
- R5: When several slots hit, res_idx is the hitting slot with the highest count of care bits set.
- R6: When two or more hitting slots share the highest care-bit count, res_idx is the lowest of their indices.
- R7: When no slot hits, res_hit is 0 and res_idx is 0.
- R8: A write issued in the same cycle as a search does not affect that search; it is visible to the next search.
- R9: res_hit and res_idx keep their values in every cycle without a search strobe.
- R10: A valid slot whose care mask is all zeros hits every key, with a care-bit count of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one slot |
| wr_slot | input | IDX_W | Slot index to load |
| wr_value | input | WIDTH | Value bits to store |
| wr_care | input | WIDTH | Care mask, 1 = bit compared, 0 = wildcard |
| wr_valid | input | 1 | Valid flag to store in the slot |
| srch_en | input | 1 | Search strobe |
| srch_key | input | WIDTH | Key to look up |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_hit | output | 1 | At least one slot hit |
| res_idx | output | IDX_W | Winning slot index, 0 on miss |

## Verification
The embedded properties check on every cycle that a miss drives the index to zero, that the result pulse follows the strobe by exactly one edge, that a reported winner really hit on the searched contents, that an empty hit vector gives a miss, and that the outputs hold between searches. Which slot wins among overlapping hits, the tie-break toward the lower index, wildcard-only entries, invalidation, and the ordering of a write against a search in the same cycle can only be shown by the bench's scenarios, which compare each result against a reference model of the table kept in the bench.

// File: rtl/tcam_lpm.sv
module tcam_lpm #(
  parameter int SLOTS = 8,
  parameter int WIDTH = 16,
  parameter int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [WIDTH-1:0] wr_value,
  input  logic [WIDTH-1:0] wr_care,
  input  logic             wr_valid,
  input  logic             srch_en,
  input  logic [WIDTH-1:0] srch_key,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx
);
  localparam int LEN_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] val_q  [SLOTS];
  logic [WIDTH-1:0] care_q [SLOTS];
  logic [SLOTS-1:0] vld_q;
  logic [SLOTS-1:0] match_vec;
  logic [LEN_W-1:0] len    [SLOTS];

  logic             best_hit;
  logic [IDX_W-1:0] best_idx;
  logic [LEN_W-1:0] best_len;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      val_q[wr_slot]  <= wr_value & wr_care;
      care_q[wr_slot] <= wr_care;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_slot] <= wr_valid;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign match_vec[s] = vld_q[s] && (((srch_key ^ val_q[s]) & care_q[s]) == '0);
    assign len[s]       = LEN_W'($countones(care_q[s]));
  end

  always_comb begin
    best_hit = 1'b0;
    best_idx = '0;
    best_len = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (match_vec[i] && (!best_hit || len[i] > best_len)) begin
        best_hit = 1'b1;
        best_idx = IDX_W'(i);
        best_len = len[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= srch_en;
      if (srch_en) begin
        res_hit <= best_hit;
        res_idx <= best_idx;
      end
    end
  end

  // R7: a miss reports index zero
  p_idx_zero_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_idx == '0);

  // R2: result pulse follows the strobe by one edge
  p_result_follows_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> res_valid);
  p_no_result_without_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !res_valid);

  // R3: a reported winner hit on the contents it was searched against
  p_winner_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> !res_hit || ((($past(match_vec) >> res_idx) & SLOTS'(1)) != '0));

  // R4: no hitting slot means a miss
  p_empty_is_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_en && match_vec == '0) |=> !res_hit);

  // R9: outputs hold between searches
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> $stable(res_hit) && $stable(res_idx));
endmodule

// File: tb/tcam_lpm_test.sv
module tcam_lpm_test;
  localparam int SLOTS = 8;
  localparam int WIDTH = 16;
  localparam int IDX_W = 3;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             wr_en = 0;
  logic [IDX_W-1:0] wr_slot = '0;
  logic [WIDTH-1:0] wr_value = '0;
  logic [WIDTH-1:0] wr_care = '0;
  logic             wr_valid = 0;
  logic             srch_en = 0;
  logic [WIDTH-1:0] srch_key = '0;
  logic             res_valid;
  logic             res_hit;
  logic [IDX_W-1:0] res_idx;

  tcam_lpm #(.SLOTS(SLOTS), .WIDTH(WIDTH), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_value(wr_value), .wr_care(wr_care), .wr_valid(wr_valid),
    .srch_en(srch_en), .srch_key(srch_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx));

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [WIDTH-1:0] m_val  [SLOTS];
  logic [WIDTH-1:0] m_care [SLOTS];
  logic             m_vld  [SLOTS];

  logic             q_hit [$];
  logic [IDX_W-1:0] q_idx [$];
  string            q_tag [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_for(input logic [WIDTH-1:0] key, output logic hit, output logic [IDX_W-1:0] idx);
    int blen;
    hit = 0; idx = '0; blen = -1;
    for (int i = 0; i < SLOTS; i++) begin
      if (m_vld[i] && ((key & m_care[i]) == (m_val[i] & m_care[i]))
          && $countones(m_care[i]) > blen) begin
        hit = 1; idx = IDX_W'(i); blen = $countones(m_care[i]);
      end
    end
  endtask

  task automatic push_expect(input logic [WIDTH-1:0] key, input string tag);
    logic h; logic [IDX_W-1:0] x;
    expect_for(key, h, x);
    q_hit.push_back(h); q_idx.push_back(x); q_tag.push_back(tag);
  endtask

  task automatic write_slot(input int s, input logic [WIDTH-1:0] v, input logic [WIDTH-1:0] c, input bit vl);
    @(negedge clk);
    wr_en = 1; wr_slot = IDX_W'(s); wr_value = v; wr_care = c; wr_valid = vl;
    @(negedge clk);
    wr_en = 0;
    m_val[s] = v; m_care[s] = c; m_vld[s] = vl;
  endtask

  task automatic search(input logic [WIDTH-1:0] key, input string tag);
    @(negedge clk);
    push_expect(key, tag);
    srch_en = 1; srch_key = key;
    @(negedge clk);
    srch_en = 0;
  endtask

  // R8: write and search in the same cycle; expectation taken before the model update
  task automatic write_and_search(input int s, input logic [WIDTH-1:0] v, input logic [WIDTH-1:0] c,
                                  input logic [WIDTH-1:0] key);
    @(negedge clk);
    push_expect(key, "R8");
    srch_en = 1; srch_key = key;
    wr_en = 1; wr_slot = IDX_W'(s); wr_value = v; wr_care = c; wr_valid = 1;
    @(negedge clk);
    srch_en = 0; wr_en = 0;
    m_val[s] = v; m_care[s] = c; m_vld[s] = 1;
  endtask

  // R2: back-to-back strobes
  task automatic burst(input int n);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [WIDTH-1:0] key;
      key = (k % 2 == 0) ? (16'hAB00 | WIDTH'($urandom & 32'hFF)) : WIDTH'($urandom);
      push_expect(key, "R2");
      srch_en = 1; srch_key = key;
      @(negedge clk);
    end
    srch_en = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && res_valid) begin
      if (q_hit.size() == 0) begin
        check(0, "R2 unexpected result", 1, 0);
      end else begin
        logic h; logic [IDX_W-1:0] x; string t;
        h = q_hit.pop_front(); x = q_idx.pop_front(); t = q_tag.pop_front();
        check(res_hit == h, {t, " hit"}, int'(res_hit), int'(h));
        check(res_idx == x, {t, " idx"}, int'(res_idx), int'(x));
      end
    end
  end

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1000000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin m_val[i] = '0; m_care[i] = '0; m_vld[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res_valid == 0, "R1 res_valid", int'(res_valid), 0);
    check(res_hit == 0, "R1 res_hit", int'(res_hit), 0);
    check(res_idx == 0, "R1 res_idx", int'(res_idx), 0);
    rst_n = 1;
    @(negedge clk);
    check(res_valid == 0, "R2 idle", int'(res_valid), 0);
    search(16'h0000, "R1");
    search(16'hFFFF, "R7");

    write_slot(2, 16'hAB00, 16'hFF00, 1);
    write_slot(5, 16'hABC0, 16'hFFF0, 1);
    write_slot(1, 16'h5555, 16'h0000, 1);
    search(16'hABCD, "R5");
    search(16'hAB12, "R5");
    search(16'h1234, "R10");
    search(16'hAB5F, "R3");

    // R9: outputs hold across idle cycles
    begin
      logic h0; logic [IDX_W-1:0] x0;
      @(negedge clk); h0 = res_hit; x0 = res_idx;
      repeat (4) @(negedge clk);
      check(res_hit == h0, "R9 hit hold", int'(res_hit), int'(h0));
      check(res_idx == x0, "R9 idx hold", int'(res_idx), int'(x0));
      check(res_valid == 0, "R2 no pulse", int'(res_valid), 0);
    end

    write_slot(6, 16'hABC0, 16'hFFF0, 1);
    search(16'hABC1, "R6");
    write_slot(3, 16'hABCF, 16'hFFF0, 1);
    search(16'hABC1, "R6");
    write_slot(3, 16'hABC0, 16'hFFF0, 0);
    search(16'hABC1, "R4");

    write_slot(7, 16'h0034, 16'h00FF, 1);
    search(16'h1234, "R3");
    write_slot(1, 16'h0000, 16'h0000, 0);
    search(16'h9999, "R7");

    write_and_search(0, 16'h9999, 16'hFFFF, 16'h9999);
    search(16'h9999, "R8");

    burst(40);
    for (int k = 0; k < 60; k++) begin
      if (k % 7 == 3)
        write_slot(k % SLOTS, 16'hAB00 | WIDTH'($urandom & 32'hF0),
                   16'hFF00 | WIDTH'($urandom & 32'hF0), ($urandom & 3) != 0);
      search(16'hAB00 | WIDTH'($urandom & 32'hFF), "R5");
    end

    repeat (3) @(negedge clk);
    check(q_hit.size() == 0, "R2 missing results", q_hit.size(), 0);
    finish_run();
  end
endmodule